// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Sequencer

This block sits between a synchronous host port and an external asynchronous static RAM of 256K sixteen-bit words. The RAM has an active-low select, an active-low read-drive enable, an active-low write strobe and one active-low enable per byte lane. The host presents one request at a time: a word address, a read/write flag, write data and a two-bit lane mask. The block accepts the request when `req_ready` is high and then plays out a fixed sequence of phases on the memory pins. Every strobe and the controller's own data drivers come from registers.

Each phase length is a parameter counted in clock cycles. The defaults suit a 125 MHz clock and the slower speed grade of such a RAM. The read access is 9 cycles (72 ns, against a 70 ns access time). The write data is driven for 1 cycle before the write strobe falls, and the strobe stays low for 7 cycles (56 ns, against a 55 ns minimum pulse). One recovery cycle follows a write and one turnaround cycle follows a read, so both the read cycle and the write cycle are at least 70 ns. Read data is captured on the last edge of the access phase and returned with a one-cycle valid pulse. Lanes that were not enabled return zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `ram_sel_n`, `ram_rd_en_n`, `ram_wr_en_n`, `ram_hi_en_n` and `ram_lo_en_n` are 1, `ram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: Lane mask bit 1 selects the upper lane (data bits 15:8) and drives `ram_hi_en_n` low. Mask bit 0 selects the lower lane (bits 7:0) and drives `ram_lo_en_n` low. Both enables hold these values for the whole selected part of the access.
- R3: An accepted read holds `ram_sel_n` and `ram_rd_en_n` low, with `ram_wr_en_n` high, for exactly ACC_CYC cycles. `rd_valid` is then high for exactly one cycle, in the first cycle after the access, carrying the value the RAM drove on the last access edge.
- R4: In `rd_data`, a lane whose mask bit was 0 reads as zero, whatever the RAM bus carried on that lane.
- R5: An accepted write with a non-zero mask holds `ram_sel_n` low with `ram_wr_en_n` high and `ram_dq_oe` high for SETUP_CYC cycles. It then holds `ram_wr_en_n` low for WP_CYC cycles. After that, all strobes return high and the drivers switch off on the same edge.
- R6: `ram_dq_oe` is high only in the setup and strobe phases of a write. It is never high while `ram_rd_en_n` is low or while `ram_sel_n` is high.
- R7: After a read, the block stays busy for TURN_CYC cycles with the RAM deselected before `req_ready` returns. A read therefore occupies ACC_CYC+TURN_CYC busy cycles.
- R8: A write with an all-zero mask completes on its accepting edge: `req_ready` stays high, no strobe falls, and the stored word is unchanged.
- R9: `ram_addr` and the driven write data stay stable for as long as `ram_sel_n` stays low.
- R10: After the write strobe rises, the block stays busy for REC_CYC more cycles with the RAM deselected. A write therefore occupies SETUP_CYC+WP_CYC+REC_CYC busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle; the request is taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask: bit 1 upper, bit 0 lower |
| rd_valid | output | 1 | One-cycle read-data strobe |
| rd_data | output | 16 | Captured read data; disabled lanes are zero |
| ram_sel_n | output | 1 | RAM select, active low |
| ram_rd_en_n | output | 1 | RAM read-drive enable, active low |
| ram_wr_en_n | output | 1 | RAM write strobe, active low |
| ram_hi_en_n | output | 1 | Upper lane enable, active low |
| ram_lo_en_n | output | 1 | Lower lane enable, active low |
| ram_addr | output | 18 | RAM word address |
| ram_dq_out | output | 16 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Enable for the controller's data drivers |
| ram_dq_in | input | 16 | Data seen on the RAM bus |

## Verification
The hardest case to reach is a write that arrives right after a read. Only then can the controller's drivers and the RAM's read output overlap, so it is the only test of whether the turnaround cycle really keeps them apart. The random mix issues reads and writes back to back at a small pool of addresses plus the two end addresses, so this ordering comes up many times. On every such pair the bench counts, at the pins, any cycle where the drivers are on while the read enable is low. A bus model in the bench drives a fixed junk pattern on lanes the RAM would leave floating, so a failure to clear disabled lanes shows up in `rd_data`.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RD_ACC,
        PH_TURN,
        PH_WR_SETUP,
        PH_WR_PULSE,
        PH_WR_REC
    } phase_e;

    // All memory-side control strobes, active low
    typedef struct packed {
        logic             sel_n;
        logic             rd_n;
        logic             wr_n;
        logic [LANES-1:0] lane_n;
    } strobe_t;

    localparam strobe_t STROBE_OFF = '{sel_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, lane_n: '1};

    function automatic logic [LANES-1:0] mask_to_lane_n(input logic [LANES-1:0] m);
        return ~m;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int r;
        r = a;
        if (b > r) r = b;
        if (c > r) r = c;
        if (d > r) r = d;
        return r;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
    import sram_lane_pkg::*;
#(
    parameter int ACC_CYC   = 9,
    parameter int SETUP_CYC = 1,
    parameter int WP_CYC    = 7,
    parameter int REC_CYC   = 1,
    parameter int TURN_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output strobe_t           strb,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              capture
);
    localparam int MAX_CYC = max4(max4(ACC_CYC, SETUP_CYC, WP_CYC, REC_CYC), TURN_CYC, 1, 1);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam int WCNT_W  = $clog2(WP_CYC + 2);

    phase_e           phase;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;
    logic             accept;
    logic             null_wr;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_ready && req_valid;
    assign null_wr   = req_write && (req_mask == '0);
    assign capture   = (phase == PH_RD_ACC) && t_done;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_done)
    );

    // Timer reload: each phase is loaded with its length minus one on entry
    always_comb begin
        t_load = 1'b0;
        t_val  = '0;
        unique case (phase)
            PH_IDLE: if (accept && !null_wr) begin
                t_load = 1'b1;
                t_val  = req_write ? CNT_W'(SETUP_CYC - 1) : CNT_W'(ACC_CYC - 1);
            end
            PH_RD_ACC: if (t_done) begin
                t_load = 1'b1;
                t_val  = CNT_W'(TURN_CYC - 1);
            end
            PH_WR_SETUP: if (t_done) begin
                t_load = 1'b1;
                t_val  = CNT_W'(WP_CYC - 1);
            end
            PH_WR_PULSE: if (t_done) begin
                t_load = 1'b1;
                t_val  = CNT_W'(REC_CYC - 1);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            strb   <= STROBE_OFF;
            addr   <= '0;
            dq_out <= '0;
            dq_oe  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (accept && !null_wr) begin
                    addr        <= req_addr;
                    strb.sel_n  <= 1'b0;
                    strb.lane_n <= mask_to_lane_n(req_mask);
                    if (req_write) begin
                        phase  <= PH_WR_SETUP;
                        dq_out <= req_wdata;
                        dq_oe  <= 1'b1;
                    end else begin
                        phase     <= PH_RD_ACC;
                        strb.rd_n <= 1'b0;
                    end
                end
                PH_RD_ACC: if (t_done) begin
                    phase <= PH_TURN;
                    strb  <= STROBE_OFF;
                end
                PH_TURN: if (t_done) phase <= PH_IDLE;
                PH_WR_SETUP: if (t_done) begin
                    phase     <= PH_WR_PULSE;
                    strb.wr_n <= 1'b0;
                end
                PH_WR_PULSE: if (t_done) begin
                    phase <= PH_WR_REC;
                    strb  <= STROBE_OFF;
                    dq_oe <= 1'b0;
                end
                PH_WR_REC: if (t_done) phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Checker-side count of cycles the write strobe has been low
    logic [WCNT_W-1:0] wr_low_cnt;
    always_ff @(posedge clk) begin
        if (rst)                 wr_low_cnt <= '0;
        else if (!strb.wr_n)     wr_low_cnt <= wr_low_cnt + 1'b1;
        else                     wr_low_cnt <= '0;
    end

    a_r6_no_drive_during_read: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> strb.rd_n);
    a_r6_drive_only_selected: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !strb.sel_n);
    a_r5_data_before_strobe: assert property (@(posedge clk) disable iff (rst)
        $fell(strb.wr_n) |-> ($past(dq_oe) && !$past(strb.sel_n)));
    a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.wr_n) |-> (wr_low_cnt == WCNT_W'(WP_CYC)));
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!strb.sel_n && !$past(strb.sel_n)) |-> ($stable(addr) && $stable(dq_out)));
    a_r7_idle_deselected: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (strb.sel_n && !dq_oe));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture
    import sram_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] keep;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign keep[l*LANE_W +: LANE_W] = {LANE_W{~lane_n[l]}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= dq_in & keep;
        end
    end

    a_r3_single_valid: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
    a_r4_disabled_lanes_zero: assert property (@(posedge clk) disable iff (rst)
        capture |=> ((rd_data & ~keep) == '0 || !$stable(lane_n) || lane_n != $past(lane_n)));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ACC_CYC   = 9,
    parameter int SETUP_CYC = 1,
    parameter int WP_CYC    = 7,
    parameter int REC_CYC   = 1,
    parameter int TURN_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ram_sel_n,
    output logic              ram_rd_en_n,
    output logic              ram_wr_en_n,
    output logic              ram_hi_en_n,
    output logic              ram_lo_en_n,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);
    strobe_t strb;
    logic    capture;

    sram_lane_seq #(
        .ACC_CYC   (ACC_CYC),
        .SETUP_CYC (SETUP_CYC),
        .WP_CYC    (WP_CYC),
        .REC_CYC   (REC_CYC),
        .TURN_CYC  (TURN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_mask),
        .strb      (strb),
        .addr      (ram_addr),
        .dq_out    (ram_dq_out),
        .dq_oe     (ram_dq_oe),
        .capture   (capture)
    );

    sram_rd_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .lane_n   (strb.lane_n),
        .dq_in    (ram_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign ram_sel_n   = strb.sel_n;
    assign ram_rd_en_n = strb.rd_n;
    assign ram_wr_en_n = strb.wr_n;
    assign ram_hi_en_n = strb.lane_n[1];
    assign ram_lo_en_n = strb.lane_n[0];

    a_r2_lanes_hold: assert property (@(posedge clk) disable iff (rst)
        (!ram_sel_n && !$past(ram_sel_n)) |-> ($stable(ram_hi_en_n) && $stable(ram_lo_en_n)));

endmodule

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;
    localparam int ACC   = 9;
    localparam int SETUP = 1;
    localparam int WP    = 7;
    localparam int REC   = 1;
    localparam int TURN  = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        ram_sel_n, ram_rd_en_n, ram_wr_en_n, ram_hi_en_n, ram_lo_en_n;
    logic [17:0] ram_addr;
    logic [15:0] ram_dq_out;
    logic        ram_dq_oe;
    logic [15:0] ram_dq_in = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sram_lane_ctrl #(
        .ACC_CYC(ACC), .SETUP_CYC(SETUP), .WP_CYC(WP), .REC_CYC(REC), .TURN_CYC(TURN)
    ) u_sram_lane_ctrl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .ram_sel_n(ram_sel_n), .ram_rd_en_n(ram_rd_en_n), .ram_wr_en_n(ram_wr_en_n),
        .ram_hi_en_n(ram_hi_en_n), .ram_lo_en_n(ram_lo_en_n),
        .ram_addr(ram_addr), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(ram_dq_in)
    );

    // Power-up contents shared by the pin model and the expected store
    function automatic logic [15:0] seed_word(input logic [17:0] a);
        logic [31:0] p;
        p = {14'd0, a} * 32'h9E37;
        return p[18:3];
    endfunction

    // ---------------- pin-level RAM model ----------------
    logic [15:0] mdl_mem [int unsigned];

    function automatic logic [15:0] mdl_get(input logic [17:0] a);
        if (mdl_mem.exists(int'(a))) return mdl_mem[int'(a)];
        return seed_word(a);
    endfunction

    always @(negedge clk) begin
        logic [15:0] w;
        if (!ram_sel_n && !ram_wr_en_n) begin
            w = mdl_get(ram_addr);
            if (!ram_lo_en_n) w[7:0]  = ram_dq_out[7:0];
            if (!ram_hi_en_n) w[15:8] = ram_dq_out[15:8];
            mdl_mem[int'(ram_addr)] = w;
        end
        // Floating lanes are modelled as a junk pattern
        w = mdl_get(ram_addr);
        ram_dq_in[7:0]  <= (!ram_sel_n && !ram_rd_en_n && ram_wr_en_n && !ram_lo_en_n) ? w[7:0]  : 8'hA5;
        ram_dq_in[15:8] <= (!ram_sel_n && !ram_rd_en_n && ram_wr_en_n && !ram_hi_en_n) ? w[15:8] : 8'h5A;
    end

    // ---------------- expected store ----------------
    logic [15:0] exp_mem [int unsigned];

    function automatic logic [15:0] exp_get(input logic [17:0] a);
        if (exp_mem.exists(int'(a))) return exp_mem[int'(a)];
        return seed_word(a);
    endfunction

    function automatic logic [15:0] lane_keep(input logic [15:0] d, input logic [1:0] m);
        return {m[1] ? d[15:8] : 8'h00, m[0] ? d[7:0] : 8'h00};
    endfunction

    function automatic logic [15:0] lane_merge(input logic [15:0] old, input logic [15:0] d,
                                               input logic [1:0] m);
        return {m[1] ? d[15:8] : old[15:8], m[0] ? d[7:0] : old[7:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] m);
        int n_acc = 0;
        int n_busy = 0;
        int n_val = 0;
        int n_clash = 0;
        logic [1:0]  lanes_seen = 2'b11;
        logic [15:0] got = '0;
        logic [15:0] expv;
        expv = lane_keep(exp_get(a), m);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_mask = m;
        req_wdata = 16'($urandom);
        @(posedge clk);
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            if (!ram_sel_n && !ram_rd_en_n && ram_wr_en_n) begin
                n_acc++;
                if (n_acc == 1) lanes_seen = {ram_hi_en_n, ram_lo_en_n};
            end
            if (rd_valid) begin n_val++; got = rd_data; end
            if (!req_ready) n_busy++;
            if (ram_dq_oe) n_clash++;
        end while (!req_ready);
        check("R3 access cycles", n_acc, ACC);
        check("R3 valid pulses", n_val, 1);
        check("R7 read busy cycles", n_busy, ACC + TURN);
        check("R2 read lane enables", {30'd0, lanes_seen}, {30'd0, ~m});
        check("R4/R3 read data", {16'd0, got}, {16'd0, expv});
        check("R6 no drive in read", n_clash, 0);
    endtask

    task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        int n_setup = 0;
        int n_pulse = 0;
        int n_busy = 0;
        int n_drive = 0;
        int n_sel = 0;
        int n_clash = 0;
        int n_move = 0;
        logic [1:0] lanes_seen = 2'b11;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_mask = m; req_wdata = d;
        @(posedge clk);
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            if (!ram_sel_n) begin
                n_sel++;
                if (n_sel == 1) lanes_seen = {ram_hi_en_n, ram_lo_en_n};
                if (ram_addr !== a || ram_dq_out !== d) n_move++;
            end
            if (!ram_sel_n && ram_wr_en_n && ram_dq_oe) n_setup++;
            if (!ram_sel_n && !ram_wr_en_n) n_pulse++;
            if (ram_dq_oe) n_drive++;
            if (ram_dq_oe && (!ram_rd_en_n || ram_sel_n)) n_clash++;
            if (!req_ready) n_busy++;
        end while (!req_ready);
        if (m == 2'b00) begin
            check("R8 null write busy", n_busy, 0);
            check("R8 null write no select", n_sel, 0);
        end else begin
            check("R5 setup cycles", n_setup, SETUP);
            check("R5 strobe cycles", n_pulse, WP);
            check("R10 write busy cycles", n_busy, SETUP + WP + REC);
            check("R6 drive cycles", n_drive, SETUP + WP);
            check("R2 write lane enables", {30'd0, lanes_seen}, {30'd0, ~m});
            check("R9 addr/data stable", n_move, 0);
        end
        check("R6 no drive clash", n_clash, 0);
        exp_mem[int'(a)] = lane_merge(exp_get(a), d, m);
    endtask

    initial begin
        logic [17:0] a;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 sel", ram_sel_n, 1);
        check("R1 rd", ram_rd_en_n, 1);
        check("R1 wr", ram_wr_en_n, 1);
        check("R1 lanes", {ram_hi_en_n, ram_lo_en_n}, 2'b11);
        check("R1 drivers", ram_dq_oe, 0);
        check("R1 valid", rd_valid, 0);
        check("R1 ready", req_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset sel", ram_sel_n, 1);
        check("R1 post-reset ready", req_ready, 1);

        // Directed corners
        do_read(18'h00000, 2'b11);
        do_write(18'h3FFFF, 16'hBEEF, 2'b11);
        do_read(18'h3FFFF, 2'b11);
        do_write(18'h00010, 16'h1234, 2'b01);   // lower lane only
        do_read(18'h00010, 2'b10);               // R4: lower reads zero
        do_read(18'h00010, 2'b01);
        do_write(18'h00010, 16'hFFFF, 2'b00);   // R8: null write
        do_read(18'h00010, 2'b11);               // R8: word unchanged
        do_read(18'h00020, 2'b00);               // R4: all lanes zero
        do_write(18'h00020, 16'hCAFE, 2'b10);   // write right after read
        do_read(18'h00020, 2'b11);

        // Random mix on a small address pool plus the end addresses
        for (int i = 0; i < 80; i++) begin
            case ($urandom % 4)
                0:       a = ($urandom % 2) ? 18'h3FFFF : 18'h00000;
                default: a = 18'($urandom % 12) + 18'h00100;
            endcase
            if ($urandom % 2) do_write(a, 16'($urandom), 2'($urandom));
            else              do_read(a, 2'($urandom));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule